// File: doc/BRIEF.md
# Multi-Cycle Carry-Save Array Multiplier

This block multiplies two unsigned W-bit operands into a 2W-bit product. Its internal timing follows a memory-array arithmetic model in which every one-bit addition costs a fixed number of cycles, STEP_CYC (13 by default). A run has three phases in a fixed order. The first phase spends one cycle forming W shifted partial products. The second phase reduces those operands to two, one carry-save level at a time, with no carry moving between bit positions. The third phase forms the final product by adding the two remaining operands. In precise mode carries ripple across all 2W bits. In approximate mode only the upper W bits ripple, and the lower W bits are formed without carries.

A one-cycle start pulse in the idle state latches the operands and the mode. The unit stays busy for the whole run. When it finishes it pulses done, and at that point it presents the product and the number of cycles the run took. Both values are held until the next run completes. A start pulse that arrives while the unit is busy has no effect. The cycle report lets a system check the phase-latency formulas directly.

Top module: `csmul_top`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, product_o and cycles_o are all zero.
- R2: A start_i pulse while idle latches a_i, b_i and approx_i. busy_o is high from the next cycle for exactly T consecutive cycles, where T is the value later reported on cycles_o.
- R3: Partial product i is a AND b[i], shifted left by i in a 2W-bit word. In each reduction level, operands 3g, 3g+1 and 3g+2 produce operand 2g (their bitwise sum) and operand 2g+1 (their majority shifted left by one, truncated to 2W bits). The one or two operands left over move, in order, to the slots that follow. Levels repeat until two operands remain, and each level lasts STEP_CYC cycles.
- R4: With approx_i=0, product_o equals a*b exactly for every pair of operands.
- R5: In precise mode T = 1 + STEP_CYC*L + STEP_CYC*2W, where L is the number of reduction levels from R3. For W=8, L=4 and T=261.
- R6: With approx_i=1, let x and y be the two final operands from R3. Bits [W-1:0] of the product are x|y on those bits. Bits [2W-1:W] equal (x>>W)+(y>>W) mod 2^W, with no carry in from below. The exact product minus this result, mod 2^(2W), is below 2^W.
- R7: In approximate mode T = 1 + STEP_CYC*L + STEP_CYC*W. For W=8, T=157.
- R8: done_o is a one-cycle pulse in the cycle after the last busy cycle. It is never high together with busy_o. product_o and cycles_o are updated only at that pulse.
- R9: A start_i pulse while busy_o is high changes neither the running result nor the latency, and it does not start a further run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| approx_i | input | 1 | 1 selects the truncated final addition |
| a_i | input | W | Multiplicand |
| b_i | input | W | Multiplier |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2W | Product of the last finished run |
| cycles_o | output | CNT_W | Cycle count of the last finished run |

## Verification
A wrong reduction grouping or a lost carry-save bit changes the sum of the final two operands. In precise mode this appears as a wrong product_o at the done pulse of that same run. In approximate mode a wrong grouping also shifts which lower bits are ORed, so the bench predicts the approximate product bit for bit. A mistimed step counter or level count shows up as a busy_o edge in the wrong cycle, and also in the reported cycles_o. The bench compares busy_o and done_o on every clock of every run, so a timing slip is caught in the cycle where it happens.

// File: rtl/csmul_pkg.sv
package csmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PPGEN  = 2'd1,
    ST_REDUCE = 2'd2,
    ST_FINAL  = 2'd3
  } phase_e;

  // Number of 3:2 levels needed to bring n operands down to two.
  function automatic int reduce_levels(input int n);
    int c;
    int l;
    c = n;
    l = 0;
    while (c > 2) begin
      c = 2 * (c / 3) + (c % 3);
      l++;
    end
    return l;
  endfunction

  // Total busy cycles of one run.
  function automatic int run_cycles(input int n, input int step, input bit approx);
    return 1 + step * reduce_levels(n) + step * (approx ? n : 2 * n);
  endfunction

endpackage

// File: rtl/csmul_step_timer.sv
module csmul_step_timer #(
  parameter int STEP_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  output logic tick
);
  localparam int TW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(STEP_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q == LAST);

  // The step counter never leaves its range (R3 level timing).
  assert_step_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/csmul_ppgen.sv
module csmul_ppgen #(
  parameter int W = 8
) (
  input  logic [W-1:0]            a,
  input  logic [W-1:0]            b,
  output logic [W-1:0][2*W-1:0]   pp
);
  localparam int OW = 2 * W;

  for (genvar i = 0; i < W; i++) begin : g_row
    assign pp[i] = b[i] ? (OW'(a) << i) : '0;
  end

endmodule

// File: rtl/csmul_csa_level.sv
module csmul_csa_level #(
  parameter int SLOTS = 8,
  parameter int OW    = 16,
  parameter int CW    = 4
) (
  input  logic [SLOTS-1:0][OW-1:0] ops_i,
  input  logic [CW-1:0]            cnt_i,
  output logic [SLOTS-1:0][OW-1:0] ops_o,
  output logic [CW-1:0]            cnt_o
);
  localparam int GMAX = SLOTS / 3;
  localparam int GN   = (GMAX > 0) ? GMAX : 1;

  logic [GN-1:0][OW-1:0] sum_w;
  logic [GN-1:0][OW-1:0] cry_w;

  if (GMAX > 0) begin : g_cells
    for (genvar g = 0; g < GMAX; g++) begin : g_fa
      logic [OW-1:0] p, q, r;
      assign p = ops_i[3*g];
      assign q = ops_i[3*g+1];
      assign r = ops_i[3*g+2];
      assign sum_w[g] = p ^ q ^ r;
      assign cry_w[g] = ((p & q) | (p & r) | (q & r)) << 1;
    end
  end else begin : g_none
    assign sum_w = '0;
    assign cry_w = '0;
  end

  logic [CW-1:0] grp;
  logic [CW-1:0] rem;

  always_comb begin
    grp   = cnt_i / CW'(3);
    rem   = cnt_i - CW'(3) * grp;
    ops_o = '0;
    for (int j = 0; j < GN; j++) begin
      if (CW'(j) < grp) begin
        ops_o[2*j]   = sum_w[j];
        ops_o[2*j+1] = cry_w[j];
      end
    end
    for (int k = 0; k < 2; k++) begin
      if (CW'(k) < rem) begin
        if ((3 * int'(grp) + k) < SLOTS && (2 * int'(grp) + k) < SLOTS)
          ops_o[2*int'(grp)+k] = ops_i[3*int'(grp)+k];
      end
    end
    cnt_o = CW'(2) * grp + rem;
  end

endmodule

// File: rtl/csmul_top.sv
module csmul_top
  import csmul_pkg::*;
#(
  parameter int W        = 8,
  parameter int STEP_CYC = 13,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             approx_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2*W-1:0]   product_o,
  output logic [CNT_W-1:0] cycles_o
);
  localparam int OW = 2 * W;
  localparam int CW = $clog2(W + 1);
  localparam int IW = $clog2(OW);
  localparam logic [IW-1:0] LAST_BIT  = IW'(OW - 1);
  localparam logic [IW-1:0] HIGH_BASE = IW'(W);

  phase_e                state;
  logic [W-1:0]          a_q, b_q;
  logic                  approx_q;
  logic [W-1:0][OW-1:0]  ops_q;
  logic [CW-1:0]         cnt_q;
  logic [IW-1:0]         bit_idx;
  logic                  carry_q;
  logic [OW-1:0]         res_q;
  logic [CNT_W-1:0]      cyc_q;

  logic [W-1:0][OW-1:0]  pp_w;
  logic [W-1:0][OW-1:0]  lvl_ops;
  logic [CW-1:0]         lvl_cnt;
  logic                  tick;

  csmul_ppgen #(.W(W)) ppgen_i (
    .a (a_q),
    .b (b_q),
    .pp(pp_w)
  );

  csmul_csa_level #(.SLOTS(W), .OW(OW), .CW(CW)) level_i (
    .ops_i(ops_q),
    .cnt_i(cnt_q),
    .ops_o(lvl_ops),
    .cnt_o(lvl_cnt)
  );

  csmul_step_timer #(.STEP_CYC(STEP_CYC)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .clear(state == ST_PPGEN),
    .en   ((state == ST_REDUCE) || (state == ST_FINAL)),
    .tick (tick)
  );

  // One ripple bit of the final addition.
  logic          xb, yb, sbit, cbit;
  logic [OW-1:0] res_nx;
  logic [OW-1:0] fin_x, fin_y;

  always_comb begin
    xb     = ops_q[0][bit_idx];
    yb     = ops_q[1][bit_idx];
    sbit   = xb ^ yb ^ carry_q;
    cbit   = (xb & yb) | (xb & carry_q) | (yb & carry_q);
    res_nx = res_q;
    res_nx[bit_idx] = sbit;
    fin_x  = (state == ST_PPGEN) ? pp_w[0] : lvl_ops[0];
    fin_y  = (state == ST_PPGEN) ? pp_w[1] : lvl_ops[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      product_o <= '0;
      cycles_o  <= '0;
      a_q       <= '0;
      b_q       <= '0;
      approx_q  <= 1'b0;
      ops_q     <= '0;
      cnt_q     <= '0;
      bit_idx   <= '0;
      carry_q   <= 1'b0;
      res_q     <= '0;
      cyc_q     <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            a_q      <= a_i;
            b_q      <= b_i;
            approx_q <= approx_i;
            busy_o   <= 1'b1;
            cyc_q    <= CNT_W'(1);
            state    <= ST_PPGEN;
          end
        end
        ST_PPGEN: begin
          cyc_q <= cyc_q + 1'b1;
          ops_q <= pp_w;
          cnt_q <= CW'(W);
          if (W > 2) begin
            state <= ST_REDUCE;
          end else begin
            state   <= ST_FINAL;
            carry_q <= 1'b0;
            if (approx_q) begin
              res_q   <= {{W{1'b0}}, fin_x[W-1:0] | fin_y[W-1:0]};
              bit_idx <= HIGH_BASE;
            end else begin
              res_q   <= '0;
              bit_idx <= '0;
            end
          end
        end
        ST_REDUCE: begin
          cyc_q <= cyc_q + 1'b1;
          if (tick) begin
            ops_q <= lvl_ops;
            cnt_q <= lvl_cnt;
            if (lvl_cnt == CW'(2)) begin
              state   <= ST_FINAL;
              carry_q <= 1'b0;
              if (approx_q) begin
                res_q   <= {{W{1'b0}}, fin_x[W-1:0] | fin_y[W-1:0]};
                bit_idx <= HIGH_BASE;
              end else begin
                res_q   <= '0;
                bit_idx <= '0;
              end
            end
          end
        end
        ST_FINAL: begin
          if (tick) begin
            res_q   <= res_nx;
            carry_q <= cbit;
            if (bit_idx == LAST_BIT) begin
              state     <= ST_IDLE;
              busy_o    <= 1'b0;
              done_o    <= 1'b1;
              product_o <= res_nx;
              cycles_o  <= cyc_q;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              cyc_q   <= cyc_q + 1'b1;
            end
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Sums of the live operands, mod 2^OW, before and after one level.
  logic [OW-1:0] sum_cur, sum_nxt;
  always_comb begin
    sum_cur = '0;
    sum_nxt = '0;
    for (int i = 0; i < W; i++) begin
      if (CW'(i) < cnt_q)   sum_cur = sum_cur + ops_q[i];
      if (CW'(i) < lvl_cnt) sum_nxt = sum_nxt + lvl_ops[i];
    end
  end

  assert_sum_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REDUCE && tick) |-> (sum_nxt == sum_cur));

  assert_level_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REDUCE && tick) |-> (lvl_cnt < cnt_q && lvl_cnt >= CW'(2)));

  assert_precise_product_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && !approx_q) |-> (product_o == OW'(a_q) * OW'(b_q)));

  assert_latency_R5_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cycles_o == CNT_W'(run_cycles(W, STEP_CYC, approx_q))));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(a_q) && $stable(b_q) && $stable(approx_q)));

endmodule

// File: tb/csmul_top_tb.sv
module csmul_top_tb_top;
  localparam int W        = 8;
  localparam int OW       = 2 * W;
  localparam int STEP_CYC = 13;
  localparam int CNT_W    = 16;

  logic             clk = 1'b0;
  logic             rst;
  logic             start_i;
  logic             approx_i;
  logic [W-1:0]     a_i, b_i;
  logic             busy_o, done_o;
  logic [OW-1:0]    product_o;
  logic [CNT_W-1:0] cycles_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  csmul_top #(.W(W), .STEP_CYC(STEP_CYC), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .approx_i(approx_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
    .product_o(product_o), .cycles_o(cycles_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reduction model, grouping as stated in R3.
  function automatic void ref_pair(input int a, input int b, output longint x,
                                   output longint y, output int lv);
    longint mask;
    longint cur[W];
    longint nxt[W];
    int cnt;
    mask = (longint'(1) << OW) - 1;
    for (int i = 0; i < W; i++) cur[i] = ((b >> i) & 1) ? ((longint'(a) << i) & mask) : 0;
    cnt = W;
    lv = 0;
    while (cnt > 2) begin
      int g, r, n;
      g = cnt / 3;
      r = cnt % 3;
      n = 0;
      for (int j = 0; j < g; j++) begin
        longint p, q, s;
        p = cur[3*j]; q = cur[3*j+1]; s = cur[3*j+2];
        nxt[n] = p ^ q ^ s;
        nxt[n+1] = (((p & q) | (p & s) | (q & s)) << 1) & mask;
        n += 2;
      end
      for (int k = 0; k < r; k++) begin
        nxt[n] = cur[3*g+k];
        n++;
      end
      for (int i = 0; i < n; i++) cur[i] = nxt[i];
      cnt = n;
      lv++;
    end
    x = cur[0];
    y = cur[1];
  endfunction

  // One run, checked cycle by cycle. inject>0 pulses start again at that busy cycle.
  task automatic run_op(input int a, input int b, input bit apx, input int inject);
    longint x, y, exact, expp, mlo, mask, diff;
    int lv, t;
    string rq;
    ref_pair(a, b, x, y, lv);
    mask  = (longint'(1) << OW) - 1;
    mlo   = (longint'(1) << W) - 1;
    exact = longint'(a) * longint'(b);
    if (apx) begin
      expp = ((((x >> W) + (y >> W)) & mlo) << W) | ((x | y) & mlo);
      t = 1 + STEP_CYC * lv + STEP_CYC * W;
      rq = "R7";
    end else begin
      expp = exact;
      t = 1 + STEP_CYC * lv + STEP_CYC * 2 * W;
      rq = "R5";
    end
    @(negedge clk);
    a_i = W'(a); b_i = W'(b); approx_i = apx; start_i = 1'b1;
    for (int k = 0; k <= t + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == (k < t), (inject > 0) ? "R9 busy" : {"R2 busy ", rq}, busy_o, (k < t));
      chk(done_o == (k == t), "R8 done pulse", done_o, (k == t));
      if (k == t) begin
        chk(cycles_o == CNT_W'(t), {rq, " cycles"}, cycles_o, t);
        if (apx) begin
          chk(product_o == OW'(expp), "R6 approx product", product_o, expp);
          diff = (exact - longint'(product_o)) & mask;
          chk(diff < (longint'(1) << W), "R6 error bound", diff, mlo);
        end else begin
          chk(product_o == OW'(expp), (inject > 0) ? "R9 product" : "R4 product", product_o, expp);
        end
      end
      if (inject > 0 && k == inject) begin
        start_i = 1'b1; a_i = ~a_i; b_i = ~b_i; approx_i = ~approx_i;
      end
    end
    // Outputs held, no new run begun (R8, R9).
    @(negedge clk);
    chk(!busy_o && !done_o, "R9 idle after run", busy_o, 0);
    chk(product_o == OW'(expp), "R8 product held", product_o, expp);
  endtask

  initial begin
    int lvs;
    longint dx, dy;
    rst = 1'b1; start_i = 1'b0; approx_i = 1'b0; a_i = '0; b_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R1 reset flags", {busy_o, done_o}, 0);
    chk(product_o == 0, "R1 reset product", product_o, 0);
    chk(cycles_o == 0, "R1 reset cycles", cycles_o, 0);
    ref_pair(1, 1, dx, dy, lvs);
    chk(lvs == 4, "R3 level count", lvs, 4);

    // Precise corners and patterns (R4, R5)
    run_op(0, 0, 0, 0);
    run_op(255, 255, 0, 0);
    run_op(1, 255, 0, 0);
    run_op(128, 128, 0, 0);
    run_op(3, 5, 0, 0);
    run_op(170, 85, 0, 0);
    for (int i = 0; i < 10; i++) run_op($urandom_range(0, 255), $urandom_range(0, 255), 0, 0);

    // Approximate mode (R6, R7)
    run_op(255, 255, 1, 0);
    run_op(0, 77, 1, 0);
    run_op(15, 15, 1, 0);
    run_op(128, 255, 1, 0);
    for (int i = 0; i < 8; i++) run_op($urandom_range(0, 255), $urandom_range(0, 255), 1, 0);

    // Start during busy ignored (R9)
    run_op(201, 99, 0, 20);
    run_op(33, 240, 1, 100);
    run_op(77, 13, 0, 250);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule